// File: doc/BRIEF.md
# DRAM Bank Strobe and Address Front-End

This block connects an 8-bit processor bus to a 32 KB main memory built from two 16 KB DRAM banks. Each bank is a pair of 4-bit-wide devices that share one column strobe. For each access the block latches the 16-bit bus address and the slot-select qualifier. It then runs a fixed strobe sequence. The row strobe falls first. The address-select then moves from the row phase to the column phase. Last, the internal column strobe falls and is steered to at most one bank.

Steering uses a 2-to-4 decode of address bits 15 and 14, gated by the slot-select input. Bank 0 serves 8000h to BFFFh and bank 1 serves C000h to FFFFh. The 14-bit in-bank address is time-multiplexed onto 8 DRAM address pins. The row phase carries 8 bits and the column phase carries 6 bits. Accesses that fall outside both banks still run the row-strobe cycle, but they assert no bank column strobe. After each access, precharge time is enforced before the next row strobe.

Top module: `dram_bank_frontend`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `ras_n_o` is 1, `cas_n_o` is 2'b11, `mux_col_o` is 0 and `ready_o` is 1.
- R2: Bank strobe `cas_n_o[0]` goes low during an access only when `slot0_i` was 1 and the address was in 8000h..BFFFh (A15=1, A14=0).
- R3: Bank strobe `cas_n_o[1]` goes low during an access only when `slot0_i` was 1 and the address was in C000h..FFFFh (A15=1, A14=1).
- R4: When the address is below 8000h or `slot0_i` was 0, both bank strobes stay high, but `ras_n_o` still completes one low pulse.
- R5: While `ras_n_o` falls and `mux_col_o` is 0, `dram_a_o[7:0]` carries A7..A0 of the access address.
- R6: While a bank strobe falls, `mux_col_o` is 1, `dram_a_o[5:0]` carries A13..A8 and `dram_a_o[7:6]` is 0.
- R7: `mux_col_o` rises at least one clock after `ras_n_o` falls, and a bank strobe falls at least one clock after `mux_col_o` rises. `mux_col_o` is 0 when `ras_n_o` falls.
- R8: At the end of an access, `ras_n_o` rises in the same cycle that both bank strobes are high and `mux_col_o` returns to 0.
- R9: `ras_n_o` has been high for at least two clock cycles before every falling edge.
- R10: The address and slot select are captured in the cycle where `req_i` is 1 and `ready_o` is 1. Later changes to `addr_i` or `slot0_i` do not affect that access.
- R11: At most one bank strobe is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Access request, accepted while ready_o is 1 |
| addr_i | input | 16 | Bus address of the access |
| slot0_i | input | 1 | 1 when slot 0 is selected for this access |
| ready_o | output | 1 | 1 when a new access can be accepted |
| ras_n_o | output | 1 | Row strobe, active low, shared by both banks |
| mux_col_o | output | 1 | Address-select: 0 for the row phase, 1 for the column phase |
| cas_n_o | output | 2 | Column strobe per bank, active low (bit 0: 8000h-BFFFh, bit 1: C000h-FFFFh) |
| dram_a_o | output | 8 | Multiplexed DRAM address pins |

## Verification
Embedded properties check, on every cycle, that no two bank strobes are low together and that a column strobe only occurs with the row strobe low and the column phase selected. They also check that the mux switches only after the row strobe has fallen, that every strobe returns high together, that the precharge gap holds, and that the captured access stays frozen while busy. Only the bench scenarios can show that the right bank is picked for each address window and slot state. The bench also shows that the row and column halves rebuild the original in-bank address, as seen by a behavioural DRAM model. It further shows that bus changes after acceptance leave the access unchanged.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam int BUS_AW    = 16;
    localparam int BANK_AW   = 14;
    localparam int DRAM_PINS = 8;
    localparam int ROW_W     = 8;
    localparam int COL_W     = BANK_AW - ROW_W;

    typedef enum logic [2:0] {
        SEQ_IDLE   = 3'd0,
        SEQ_ROW    = 3'd1,
        SEQ_SWITCH = 3'd2,
        SEQ_COL    = 3'd3,
        SEQ_PRE    = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic              slot;
    } access_t;

    // 2-line to 4-line decode of the top address bits, gated by slot select
    function automatic logic [3:0] quarter_decode(input logic slot, input logic [1:0] top);
        logic [3:0] d;
        d = 4'b0000;
        if (slot) d[top] = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/dbf_bank_decoder.sv
module dbf_bank_decoder
    import dbf_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BASE_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cas_raw_n,
    input  logic                 slot,
    input  logic [1:0]           top_bits,
    output logic [NUM_BANKS-1:0] cas_n
);
    logic [3:0] lines;

    always_comb lines = quarter_decode(slot, top_bits);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb cas_n[b] = cas_raw_n | ~lines[BASE_LINE + b];
    end

    assert_one_bank_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cas_n));

    assert_bank_follows_raw_R2: assert property (@(posedge clk) disable iff (rst)
        (cas_n != {NUM_BANKS{1'b1}}) |-> (!cas_raw_n && slot && top_bits[1]));

endmodule

// File: rtl/dbf_addr_mux.sv
module dbf_addr_mux
    import dbf_pkg::*;
(
    input  logic                 col_sel,
    input  logic [BANK_AW-1:0]   bank_addr,
    output logic [DRAM_PINS-1:0] pins
);
    localparam int PAD_W = DRAM_PINS - COL_W;

    logic [DRAM_PINS-1:0] col_word;

    if (PAD_W > 0) begin : g_pad
        always_comb col_word = {{PAD_W{1'b0}}, bank_addr[BANK_AW-1:ROW_W]};
    end else begin : g_nopad
        always_comb col_word = bank_addr[ROW_W +: DRAM_PINS];
    end

    always_comb pins = col_sel ? col_word : bank_addr[ROW_W-1:0];

endmodule

// File: rtl/dbf_sequencer.sv
module dbf_sequencer
    import dbf_pkg::*;
#(
    parameter int CAS_CYCLES = 2,
    parameter int PRE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic accept,
    output logic ready,
    output logic ras_n,
    output logic mux_col,
    output logic cas_raw_n
);
    localparam int MAXC  = (CAS_CYCLES > PRE_CYCLES) ? CAS_CYCLES : PRE_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SEQ_IDLE:   if (req) state <= SEQ_ROW;
                SEQ_ROW:    state <= SEQ_SWITCH;
                SEQ_SWITCH: begin
                    state <= SEQ_COL;
                    cnt   <= CNT_W'(CAS_CYCLES - 1);
                end
                SEQ_COL: begin
                    if (cnt == '0) begin
                        state <= SEQ_PRE;
                        cnt   <= CNT_W'(PRE_CYCLES - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_PRE: begin
                    if (cnt == '0) state <= SEQ_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        ready     = (state == SEQ_IDLE);
        accept    = ready && req;
        ras_n     = (state == SEQ_IDLE) || (state == SEQ_PRE);
        mux_col   = (state == SEQ_SWITCH) || (state == SEQ_COL);
        cas_raw_n = (state != SEQ_COL);
    end

    assert_precharge_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> ($past(ras_n, 1) && $past(ras_n, 2)));

    assert_col_inside_row_R7: assert property (@(posedge clk) disable iff (rst)
        !cas_raw_n |-> (!ras_n && mux_col));

    assert_mux_after_row_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mux_col) |-> $past(!ras_n));

    assert_end_together_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (cas_raw_n && !mux_col && $past(!cas_raw_n)));

endmodule

// File: rtl/dram_bank_frontend.sv
module dram_bank_frontend
    import dbf_pkg::*;
#(
    parameter int CAS_CYCLES = 2,
    parameter int PRE_CYCLES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [BUS_AW-1:0]    addr_i,
    input  logic                 slot0_i,
    output logic                 ready_o,
    output logic                 ras_n_o,
    output logic                 mux_col_o,
    output logic [1:0]           cas_n_o,
    output logic [DRAM_PINS-1:0] dram_a_o
);
    access_t acc_q;
    logic    accept;
    logic    cas_raw_n;

    dbf_sequencer #(
        .CAS_CYCLES(CAS_CYCLES),
        .PRE_CYCLES(PRE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (req_i),
        .accept   (accept),
        .ready    (ready_o),
        .ras_n    (ras_n_o),
        .mux_col  (mux_col_o),
        .cas_raw_n(cas_raw_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (accept) begin
            acc_q.addr <= addr_i;
            acc_q.slot <= slot0_i;
        end
    end

    dbf_bank_decoder #(
        .NUM_BANKS(2),
        .BASE_LINE(2)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .cas_raw_n(cas_raw_n),
        .slot     (acc_q.slot),
        .top_bits (acc_q.addr[BUS_AW-1:BUS_AW-2]),
        .cas_n    (cas_n_o)
    );

    dbf_addr_mux u_mux (
        .col_sel  (mux_col_o),
        .bank_addr(acc_q.addr[BANK_AW-1:0]),
        .pins     (dram_a_o)
    );

    assert_capture_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(ready_o) && !$past(rst)) |-> $stable(acc_q));

endmodule

// File: tb/dram_bank_frontend_test.sv
module dram_bank_frontend_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic        slot0_i = 1'b0;
    logic        ready_o, ras_n_o, mux_col_o;
    logic [1:0]  cas_n_o;
    logic [7:0]  dram_a_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int ras_rises = 0;

    logic [15:0] exp_addr = '0;
    logic [1:0]  exp_mask = '0;

    always #5 clk = ~clk;

    dram_bank_frontend uut (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .slot0_i(slot0_i),
        .ready_o(ready_o), .ras_n_o(ras_n_o), .mux_col_o(mux_col_o),
        .cas_n_o(cas_n_o), .dram_a_o(dram_a_o)
    );

    function automatic logic [1:0] bank_mask(input logic [15:0] a, input logic s);
        if (!s || !a[15]) return 2'b00;
        return a[14] ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // behavioural DRAM model and protocol monitor
    logic       prev_ras = 1'b1, prev_mux = 1'b0;
    logic [1:0] prev_cas = 2'b11;
    int         hi_cnt = 0, lo_cnt = 0, mux_cnt = 0;
    logic [7:0] row_cap = '0;
    logic [5:0] col_cap = '0;
    logic [1:0] got_mask = '0;

    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(1'b0, "watchdog", cycles, 20000);
            finish_run();
        end
        if (!rst) begin
            if (prev_ras && !ras_n_o) begin
                check(hi_cnt >= 2, "R9 precharge", hi_cnt, 2);
                check(!mux_col_o, "R7 mux at ras fall", mux_col_o, 0);
                row_cap  = dram_a_o;
                got_mask = 2'b00;
                check(dram_a_o == exp_addr[7:0], "R5 row pins", dram_a_o, exp_addr[7:0]);
            end
            if (!prev_mux && mux_col_o)
                check(!ras_n_o && lo_cnt >= 1, "R7 mux after ras", lo_cnt, 1);
            for (int b = 0; b < 2; b++) begin
                if (prev_cas[b] && !cas_n_o[b]) begin
                    check(mux_col_o && prev_mux, "R7 cas after mux", mux_cnt, 1);
                    check(dram_a_o[7:6] == 2'b00, "R6 upper pins", dram_a_o, {2'b00, exp_addr[13:8]});
                    check(dram_a_o[5:0] == exp_addr[13:8], "R6 column pins", dram_a_o, exp_addr[13:8]);
                    col_cap = dram_a_o[5:0];
                    got_mask[b] = 1'b1;
                end
            end
            if (cas_n_o == 2'b00) check(1'b0, "R11 two banks", cas_n_o, 2'b01);
            if (!prev_ras && ras_n_o) begin
                check(cas_n_o == 2'b11 && !mux_col_o, "R8 end together", {mux_col_o, cas_n_o}, 3'b011);
                check(got_mask == exp_mask, exp_mask[1] ? "R3 bank1 select" :
                      exp_mask[0] ? "R2 bank0 select" : "R4 no bank", got_mask, exp_mask);
                if (exp_mask != 2'b00)
                    check({col_cap, row_cap} == exp_addr[13:0], "R10 captured address",
                          {col_cap, row_cap}, exp_addr[13:0]);
                ras_rises++;
            end
        end
        hi_cnt  = ras_n_o ? hi_cnt + 1 : 0;
        lo_cnt  = ras_n_o ? 0 : lo_cnt + 1;
        mux_cnt = mux_col_o ? mux_cnt + 1 : 0;
        prev_ras = ras_n_o;
        prev_mux = mux_col_o;
        prev_cas = cas_n_o;
    end

    task automatic run_access(input logic [15:0] a, input logic s);
        int start;
        while (!ready_o) @(negedge clk);
        start    = ras_rises;
        exp_addr = a;
        exp_mask = bank_mask(a, s);
        addr_i   = a;
        slot0_i  = s;
        req_i    = 1'b1;
        @(negedge clk);
        req_i   = 1'b0;
        addr_i  = 16'($urandom);   // R10: bus changes after acceptance
        slot0_i = 1'($urandom);
        while (ras_rises == start) @(negedge clk);
        check(ras_rises == start + 1, "R4 row strobe cycled", ras_rises, start + 1);
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        check(ras_n_o && cas_n_o == 2'b11 && !mux_col_o && ready_o, "R1 in reset",
              {ras_n_o, cas_n_o, mux_col_o, ready_o}, 5'b11101);
        rst = 1'b0;
        @(negedge clk);
        check(ras_n_o && cas_n_o == 2'b11 && !mux_col_o && ready_o, "R1 after reset",
              {ras_n_o, cas_n_o, mux_col_o, ready_o}, 5'b11101);
        run_access(16'h7FFF, 1'b1);
        run_access(16'h8000, 1'b1);
        run_access(16'hBFFF, 1'b1);
        run_access(16'hC000, 1'b1);
        run_access(16'hFFFF, 1'b1);
        run_access(16'hC3A5, 1'b0);
        run_access(16'h0000, 1'b1);
        run_access(16'h9A5C, 1'b1);
        for (int i = 0; i < 60; i++)
            run_access(16'($urandom), ($urandom % 4) != 0);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule